// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the timing skeleton of a video raster from a single pixel-rate clock: horizontal sync, vertical sync, a data-enable that marks visible pixels, a field identifier, a start-of-frame strobe and the current pixel and line position. The horizontal line is built from four segments (visible pixels, front porch, sync, back porch) and each field is built the same way from lines. Both polarities of the two sync outputs are selectable.

Progressive and interlaced scanning are supported. In interlaced mode the programmed visible height describes the whole frame and is split between two fields; the second field has its own vertical porch and sync lengths. When the visible height is odd, a mode bit picks which field receives the extra line. A further option delays the first field's vertical sync window by half a line, so the porch before it is half a line longer and the porch after it half a line shorter, which equalises the two fields in half-lines.

All configuration inputs are captured while reset is held and then only at the wrap from the last pixel of a frame to the first pixel of the next, so software may change them at any moment without producing a broken frame. All outputs are decoded from the current registered position, so they change on the clock edge that moves the position.

Top module: `raster_timing_gen`

## Requirements
- R1: A line lasts h_act + h_fp + h_sw + h_bp clocks; h_pos counts 0 upward; the horizontal sync window covers h_pos from h_act + h_fp for h_sw clocks; de is 1 only when h_pos < h_act and the line is a visible line of the current field.
- R2: cfg_pol bit 1 sets the horizontal sync polarity and bit 0 the vertical sync polarity; 1 drives the output high inside its window, 0 drives it low inside its window.
- R3: In progressive mode (cfg_interlace = 0) every frame is one field of v_act visible lines, then v_fp, v_sw and v_bp lines; vertical sync covers v_pos from v_act + v_fp for v_sw lines; field stays 0 and the three second-field values have no effect on any output.
- R4: In interlaced mode the frame is two fields; the blanking after the first field's visible lines uses v_fp, v_sw, v_bp and the blanking after the second field's visible lines uses f2_fp, f2_sw, f2_bp; v_pos restarts at 0 for each field.
- R5: In interlaced mode each field carries floor(v_act / 2) visible lines; when v_act is odd the extra line goes to the first field if cfg_odd_first = 1 and to the second field otherwise.
- R6: With interlaced mode and cfg_half_line = 1, the first field's vertical sync window starts at h_pos = floor(line_total / 2) of line v_act1 + v_fp and ends at the same pixel v_sw lines later; the second field's vertical sync stays line-aligned and horizontal sync is unaffected.
- R7: field is 0 for the first field's visible lines, becomes 1 at the first line of the first field's vertical front porch, stays 1 for the second field's visible lines and returns to 0 at the first line of the second field's front porch; it changes only when h_pos = 0.
- R8: Configuration inputs are taken while rst_n = 0 and at the wrap into the first pixel of a frame; a change at any other time has no effect until that wrap.
- R9: sof is 1 for exactly one clock, at h_pos = 0, v_pos = 0 of the first field, once per frame, so successive pulses are one frame length apart.
- R10: While rst_n = 0 the position is held at h_pos = 0, v_pos = 0 of the first field, so de = 1, sof = 1, field = 0 and both syncs sit at their inactive level.
- R11: h_pos and v_pos report the pixel within the line and the line within the current field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_h_act | input | CNT_W | Visible pixels per line |
| cfg_h_fp | input | CNT_W | Horizontal front porch, pixels |
| cfg_h_sw | input | CNT_W | Horizontal sync width, pixels |
| cfg_h_bp | input | CNT_W | Horizontal back porch, pixels |
| cfg_v_act | input | CNT_W | Visible lines per frame |
| cfg_v_fp | input | CNT_W | Vertical front porch, lines (first field) |
| cfg_v_sw | input | CNT_W | Vertical sync width, lines (first field) |
| cfg_v_bp | input | CNT_W | Vertical back porch, lines (first field) |
| cfg_f2_fp | input | CNT_W | Second-field vertical front porch, lines |
| cfg_f2_sw | input | CNT_W | Second-field vertical sync width, lines |
| cfg_f2_bp | input | CNT_W | Second-field vertical back porch, lines |
| cfg_interlace | input | 1 | 1 selects interlaced scanning |
| cfg_half_line | input | 1 | 1 shifts the first field's vertical sync by half a line |
| cfg_odd_first | input | 1 | 1 gives an odd extra line to the first field |
| cfg_pol | input | 2 | Sync polarity mask: bit 1 horizontal, bit 0 vertical, 1 = active high |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, visible pixel |
| field | output | 1 | Field identifier |
| sof | output | 1 | Start-of-frame strobe |
| h_pos | output | CNT_W | Pixel position in the line |
| v_pos | output | CNT_W | Line position in the field |

## Verification
Every output is a decode of the registered position, so it is due in the same cycle as the position it describes; a new configuration is due at the first pixel after the frame wrap, one edge after the last pixel of the old frame. The bench keeps a flat pixel index per frame that advances on the same edges as the design, reloads its own copy of the configuration exactly at the wrap, and compares every output on the falling edge that follows. Edge-to-edge distances (line period, data-enable fall to vertical sync, vertical sync width, frame period) are counted in whole clocks on those same falling edges and compared with closed-form values from the requirements.

// File: rtl/rtg_pkg.sv
// Shared definitions for the raster timing generator.
// Assumes: segment arrays are indexed with the constants below.
package rtg_pkg;

    // Field identifier encoding
    typedef enum logic {
        FIELD_ODD  = 1'b0,
        FIELD_EVEN = 1'b1
    } rtg_field_e;

    // Mode flags captured with the timing values
    typedef struct packed {
        logic       interlace;
        logic       half_line;
        logic       odd_first;
        logic [1:0] pol;
    } rtg_mode_t;

    // Index of each segment inside a four-entry timing array
    localparam int SEG_ACT  = 0;
    localparam int SEG_FP   = 1;
    localparam int SEG_SYNC = 2;
    localparam int SEG_BP   = 3;

    // Index of each entry inside the three-entry second-field array
    localparam int F2_FP   = 0;
    localparam int F2_SYNC = 1;
    localparam int F2_BP   = 2;

    // Polarity mask bit positions
    localparam int POL_V_BIT = 0;
    localparam int POL_H_BIT = 1;

    // Turn a logical sync level into a pin level
    function automatic logic rtg_drive_pol(input logic level, input logic act_high);
        return act_high ? level : ~level;
    endfunction

endpackage

// File: rtl/rtg_cfg_reg.sv
// Configuration holding register.
// Captures every configuration input while reset is held and when load is
// high (the last pixel of a frame); otherwise holds its value, so the
// counters always see one consistent set for a whole frame.
module rtg_cfg_reg
    import rtg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [3:0][W-1:0]   h_in,
    input  logic [3:0][W-1:0]   v_in,
    input  logic [2:0][W-1:0]   f2_in,
    input  rtg_mode_t           mode_in,
    output logic [3:0][W-1:0]   h_q,
    output logic [3:0][W-1:0]   v_q,
    output logic [2:0][W-1:0]   f2_q,
    output rtg_mode_t           mode_q
);

    // Capture on reset or at the frame wrap, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            h_q    <= h_in;
            v_q    <= v_in;
            f2_q   <= f2_in;
            mode_q <= mode_in;
        end
    end

endmodule

// File: rtl/rtg_hcounter.sv
// Horizontal pixel counter and line-segment decoder.
// Counts 0 .. line_total-1 and flags the visible region, the sync window,
// the last pixel and the second half of the line.
// Assumes: the four segment sums fit in W bits and the line total is >= 2.
module rtg_hcounter
    import rtg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0][W-1:0] h_cfg,
    output logic [W-1:0]      h_pos,
    output logic [W-1:0]      h_mid,
    output logic              line_end,
    output logic              h_visible,
    output logic              hsync_lvl,
    output logic              past_mid
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] sync_on;
    logic [W-1:0] sync_off;
    logic [W-1:0] line_total;

    // Segment boundaries of the line
    always_comb begin
        sync_on    = h_cfg[SEG_ACT] + h_cfg[SEG_FP];
        sync_off   = sync_on + h_cfg[SEG_SYNC];
        line_total = sync_off + h_cfg[SEG_BP];
        h_mid      = line_total >> 1;
    end

    // Pixel counter, wraps at the end of the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_pos <= '0;
        end else if (line_end) begin
            h_pos <= '0;
        end else begin
            h_pos <= h_pos + ONE;
        end
    end

    // Position flags
    always_comb begin
        line_end  = (h_pos == line_total - ONE);
        h_visible = (h_pos < h_cfg[SEG_ACT]);
        hsync_lvl = (h_pos >= sync_on) && (h_pos < sync_off);
        past_mid  = (h_pos >= h_mid);
    end

endmodule

// File: rtl/rtg_vsequencer.sv
// Vertical line counter and field sequencer.
// Steps one line per line_end, walks the visible, front porch, sync and
// back porch lines of the current field, alternates fields in interlaced
// mode and flags the last pixel of the frame.
// Assumes: each field has at least one line and sums fit in W bits.
module rtg_vsequencer
    import rtg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              past_mid,
    input  logic [3:0][W-1:0] v_cfg,
    input  logic [2:0][W-1:0] f2_cfg,
    input  rtg_mode_t         mode,
    output logic [W-1:0]      v_pos,
    output rtg_field_e        phase,
    output logic              v_visible,
    output logic              vsync_lvl,
    output logic              frame_end
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] half_rows;
    logic         odd_rows;
    logic [W-1:0] act_first;
    logic [W-1:0] act_second;
    logic [W-1:0] cur_act;
    logic [W-1:0] cur_fp;
    logic [W-1:0] cur_sync;
    logic [W-1:0] cur_bp;
    logic [W-1:0] vs_start;
    logic [W-1:0] vs_stop;
    logic [W-1:0] last_line;
    logic         shifted;
    logic         field_end;

    // Split of the visible lines between the two fields
    always_comb begin
        half_rows  = v_cfg[SEG_ACT] >> 1;
        odd_rows   = v_cfg[SEG_ACT][0];
        act_first  = mode.interlace
                   ? half_rows + {{(W-1){1'b0}}, odd_rows & mode.odd_first}
                   : v_cfg[SEG_ACT];
        act_second = half_rows + {{(W-1){1'b0}}, odd_rows & ~mode.odd_first};
    end

    // Timing set of the field in progress
    always_comb begin
        if (phase == FIELD_EVEN) begin
            cur_act  = act_second;
            cur_fp   = f2_cfg[F2_FP];
            cur_sync = f2_cfg[F2_SYNC];
            cur_bp   = f2_cfg[F2_BP];
        end else begin
            cur_act  = act_first;
            cur_fp   = v_cfg[SEG_FP];
            cur_sync = v_cfg[SEG_SYNC];
            cur_bp   = v_cfg[SEG_BP];
        end
        vs_start  = cur_act + cur_fp;
        vs_stop   = vs_start + cur_sync;
        last_line = vs_stop + cur_bp - ONE;
    end

    // Vertical sync window, delayed by half a line when the shift applies
    always_comb begin
        shifted = mode.interlace && mode.half_line && (phase == FIELD_ODD);
        if (shifted) begin
            vsync_lvl = ((v_pos == vs_start) && past_mid)
                     || ((v_pos > vs_start) && (v_pos < vs_stop))
                     || ((v_pos == vs_stop) && !past_mid);
        end else begin
            vsync_lvl = (v_pos >= vs_start) && (v_pos < vs_stop);
        end
        v_visible = (v_pos < cur_act);
    end

    // Field and frame boundaries
    always_comb begin
        field_end = line_end && (v_pos == last_line);
        frame_end = field_end && (!mode.interlace || (phase == FIELD_EVEN));
    end

    // Line counter within the field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_pos <= '0;
        end else if (field_end) begin
            v_pos <= '0;
        end else if (line_end) begin
            v_pos <= v_pos + ONE;
        end
    end

    // Field sequencer, back to the first field at each frame wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= FIELD_ODD;
        end else if (frame_end) begin
            phase <= FIELD_ODD;
        end else if (field_end) begin
            phase <= (phase == FIELD_ODD) ? FIELD_EVEN : FIELD_ODD;
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
// Programmable raster timing generator, top level.
// Holds the configuration for a whole frame, runs the pixel and line
// counters and decodes syncs, data enable, field and start of frame from
// the current position. Outputs follow the registered position directly.
// Assumes: every segment sum fits in CNT_W bits, each sync width >= 1 and
// in interlaced mode the visible height is at least 2.
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_h_act,
    input  logic [CNT_W-1:0] cfg_h_fp,
    input  logic [CNT_W-1:0] cfg_h_sw,
    input  logic [CNT_W-1:0] cfg_h_bp,
    input  logic [CNT_W-1:0] cfg_v_act,
    input  logic [CNT_W-1:0] cfg_v_fp,
    input  logic [CNT_W-1:0] cfg_v_sw,
    input  logic [CNT_W-1:0] cfg_v_bp,
    input  logic [CNT_W-1:0] cfg_f2_fp,
    input  logic [CNT_W-1:0] cfg_f2_sw,
    input  logic [CNT_W-1:0] cfg_f2_bp,
    input  logic             cfg_interlace,
    input  logic             cfg_half_line,
    input  logic             cfg_odd_first,
    input  logic [1:0]       cfg_pol,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             field,
    output logic             sof,
    output logic [CNT_W-1:0] h_pos,
    output logic [CNT_W-1:0] v_pos
);

    logic [3:0][CNT_W-1:0] h_cfg_in;
    logic [3:0][CNT_W-1:0] v_cfg_in;
    logic [2:0][CNT_W-1:0] f2_cfg_in;
    rtg_mode_t             mode_in;
    logic [3:0][CNT_W-1:0] h_cfg_q;
    logic [3:0][CNT_W-1:0] v_cfg_q;
    logic [2:0][CNT_W-1:0] f2_cfg_q;
    rtg_mode_t             mode_q;

    logic [CNT_W-1:0] h_mid;
    logic             line_end;
    logic             h_visible;
    logic             hsync_lvl;
    logic             past_mid;
    rtg_field_e       phase;
    logic             v_visible;
    logic             vsync_lvl;
    logic             frame_end;

    // Gather the configuration pins into segment arrays
    always_comb begin
        h_cfg_in[SEG_ACT]   = cfg_h_act;
        h_cfg_in[SEG_FP]    = cfg_h_fp;
        h_cfg_in[SEG_SYNC]  = cfg_h_sw;
        h_cfg_in[SEG_BP]    = cfg_h_bp;
        v_cfg_in[SEG_ACT]   = cfg_v_act;
        v_cfg_in[SEG_FP]    = cfg_v_fp;
        v_cfg_in[SEG_SYNC]  = cfg_v_sw;
        v_cfg_in[SEG_BP]    = cfg_v_bp;
        f2_cfg_in[F2_FP]    = cfg_f2_fp;
        f2_cfg_in[F2_SYNC]  = cfg_f2_sw;
        f2_cfg_in[F2_BP]    = cfg_f2_bp;
        mode_in.interlace   = cfg_interlace;
        mode_in.half_line   = cfg_half_line;
        mode_in.odd_first   = cfg_odd_first;
        mode_in.pol         = cfg_pol;
    end

    rtg_cfg_reg #(.W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_end),
        .h_in    (h_cfg_in),
        .v_in    (v_cfg_in),
        .f2_in   (f2_cfg_in),
        .mode_in (mode_in),
        .h_q     (h_cfg_q),
        .v_q     (v_cfg_q),
        .f2_q    (f2_cfg_q),
        .mode_q  (mode_q)
    );

    rtg_hcounter #(.W(CNT_W)) u_hcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_cfg     (h_cfg_q),
        .h_pos     (h_pos),
        .h_mid     (h_mid),
        .line_end  (line_end),
        .h_visible (h_visible),
        .hsync_lvl (hsync_lvl),
        .past_mid  (past_mid)
    );

    rtg_vsequencer #(.W(CNT_W)) u_vseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .past_mid  (past_mid),
        .v_cfg     (v_cfg_q),
        .f2_cfg    (f2_cfg_q),
        .mode      (mode_q),
        .v_pos     (v_pos),
        .phase     (phase),
        .v_visible (v_visible),
        .vsync_lvl (vsync_lvl),
        .frame_end (frame_end)
    );

    // Output decode from the current position
    always_comb begin
        hsync = rtg_drive_pol(hsync_lvl, mode_q.pol[POL_H_BIT]);
        vsync = rtg_drive_pol(vsync_lvl, mode_q.pol[POL_V_BIT]);
        de    = h_visible && v_visible;
        field = mode_q.interlace && (logic'(phase) ^ ~v_visible);
        sof   = (h_pos == '0) && (v_pos == '0) && (phase == FIELD_ODD);
    end

endmodule

// File: rtl/rtg_checker.sv
// Property checker for the raster timing generator, bound to the top.
// Watches the outputs together with the held configuration and the
// internal sync level and frame wrap flag.
module rtg_checker #(
    parameter int W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      h_pos,
    input logic [W-1:0]      v_pos,
    input logic              de,
    input logic              field,
    input logic              sof,
    input logic              vsync_lvl,
    input logic              frame_end,
    input logic              interlace_q,
    input logic [W-1:0]      h_mid,
    input logic [3:0][W-1:0] h_cfg_q,
    input logic [3:0][W-1:0] v_cfg_q
);

    // R8: the held configuration only moves at the frame wrap
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(h_cfg_q) && $stable(v_cfg_q)));

    // R9: start of frame sits on the first visible pixel of the first field
    p_sof_first_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (de && !field && (h_pos == '0) && (v_pos == '0)));

    // R9: start of frame lasts one clock
    p_sof_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    // R1: data enable never reaches beyond the visible pixels
    p_de_inside_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (h_pos < h_cfg_q[0]));

    // R3: progressive scanning keeps the field at 0
    p_prog_field_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !interlace_q |-> !field);

    // R7: the field changes only at the start of a line
    p_field_at_line_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (field != $past(field)) |-> (h_pos == '0));

    // R6: vertical sync moves only at line start or mid-line
    p_vsync_edge_place_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_lvl != $past(vsync_lvl)) |-> ((h_pos == '0) || (h_pos == h_mid)));

    // R11: the pixel position steps by one inside a line
    p_hpos_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos != '0) |-> (h_pos == $past(h_pos) + {{(W-1){1'b0}}, 1'b1}));

endmodule

bind raster_timing_gen rtg_checker #(.W(CNT_W)) u_rtg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_pos       (h_pos),
    .v_pos       (v_pos),
    .de          (de),
    .field       (field),
    .sof         (sof),
    .vsync_lvl   (vsync_lvl),
    .frame_end   (frame_end),
    .interlace_q (mode_q.interlace),
    .h_mid       (h_mid),
    .h_cfg_q     (h_cfg_q),
    .v_cfg_q     (v_cfg_q)
);

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
// Bench: behavioural frame-index model compared on every falling edge,
// plus edge-distance measurements against closed-form values.
module test_raster_timing_gen;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] h_act, h_fp, h_sw, h_bp;
    logic [W-1:0] v_act, v_fp, v_sw, v_bp;
    logic [W-1:0] f2_fp, f2_sw, f2_bp;
    logic         ilace, halfl, oddf;
    logic [1:0]   pol;
    logic         hsync, vsync, de, field, sof;
    logic [W-1:0] h_pos, v_pos;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit pending = 0;

    always #4 clk = ~clk;

    raster_timing_gen #(.CNT_W(W)) i_raster_timing_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_h_act(h_act), .cfg_h_fp(h_fp), .cfg_h_sw(h_sw), .cfg_h_bp(h_bp),
        .cfg_v_act(v_act), .cfg_v_fp(v_fp), .cfg_v_sw(v_sw), .cfg_v_bp(v_bp),
        .cfg_f2_fp(f2_fp), .cfg_f2_sw(f2_sw), .cfg_f2_bp(f2_bp),
        .cfg_interlace(ilace), .cfg_half_line(halfl), .cfg_odd_first(oddf),
        .cfg_pol(pol),
        .hsync(hsync), .vsync(vsync), .de(de), .field(field), .sof(sof),
        .h_pos(h_pos), .v_pos(v_pos)
    );

    // model configuration and frame pixel index
    int m_ha, m_hf, m_hs, m_hb, m_va, m_vf, m_vs, m_vb, m_2f, m_2s, m_2b;
    int m_il, m_half, m_odd, m_pol;
    int t = 0;
    // model results
    int e_h, e_v, e_ph, e_de, e_field, e_sof, e_hs, e_vs;
    int e_htot, e_act, e_fp, e_sy, e_mid, e_shift, e_flen;

    task automatic model_load();
        m_ha = h_act; m_hf = h_fp; m_hs = h_sw; m_hb = h_bp;
        m_va = v_act; m_vf = v_fp; m_vs = v_sw; m_vb = v_bp;
        m_2f = f2_fp; m_2s = f2_sw; m_2b = f2_bp;
        m_il = ilace; m_half = halfl; m_odd = oddf; m_pol = pol;
        pending = 0;
    endtask

    task automatic model_eval();
        int a1, a2, len1, len2, line, st, sp;
        e_htot = m_ha + m_hf + m_hs + m_hb;
        e_mid  = e_htot / 2;
        if (m_il != 0) begin
            a1 = m_va / 2 + (((m_va % 2) == 1 && m_odd != 0) ? 1 : 0);
            a2 = m_va / 2 + (((m_va % 2) == 1 && m_odd == 0) ? 1 : 0);
            len1 = a1 + m_vf + m_vs + m_vb;
            len2 = a2 + m_2f + m_2s + m_2b;
        end else begin
            a1 = m_va; a2 = 0;
            len1 = a1 + m_vf + m_vs + m_vb;
            len2 = 0;
        end
        e_flen = (len1 + len2) * e_htot;
        line = t / e_htot;
        e_h  = t % e_htot;
        if (line < len1) begin
            e_ph = 0; e_v = line; e_act = a1; e_fp = m_vf; e_sy = m_vs;
        end else begin
            e_ph = 1; e_v = line - len1; e_act = a2; e_fp = m_2f; e_sy = m_2s;
        end
        e_de    = (e_h < m_ha && e_v < e_act) ? 1 : 0;
        e_field = (m_il != 0) ? (e_ph ^ ((e_v >= e_act) ? 1 : 0)) : 0;
        e_sof   = (t == 0) ? 1 : 0;
        e_hs    = (e_h >= m_ha + m_hf && e_h < m_ha + m_hf + m_hs) ? 1 : 0;
        st = e_act + e_fp; sp = st + e_sy;
        e_shift = (m_il != 0 && m_half != 0 && e_ph == 0) ? 1 : 0;
        if (e_shift != 0)
            e_vs = ((e_v == st && e_h >= e_mid) || (e_v > st && e_v < sp) ||
                    (e_v == sp && e_h < e_mid)) ? 1 : 0;
        else
            e_vs = (e_v >= st && e_v < sp) ? 1 : 0;
    endtask

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    // model advances on the same edges as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            t = 0;
            model_load();
        end else begin
            model_eval();
            if (t == e_flen - 1) begin
                t = 0;
                model_load();
            end else begin
                t = t + 1;
            end
        end
    end

    // measurement state
    int  hs_cnt = 0, de_cnt = 0, vs_cnt = 0, sof_cnt = 0, sof_exp = 0;
    bit  hs_arm = 0, sof_seen = 0;
    int  hs_prev = 0, vs_prev = 0, de_prev = 0;

    // per-cycle comparison and edge distance checks
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tv, td;
            int hs_l, vs_l;
            model_eval();
            tv = pending ? "R8" : (m_il == 0 ? "R3" : (m_half != 0 ? "R6" : "R4"));
            td = pending ? "R8" : (m_il == 0 ? "R1" : "R5");
            chk(pending ? "R8" : "R11", "h_pos", h_pos, e_h);
            chk(pending ? "R8" : "R11", "v_pos", v_pos, e_v);
            chk(pending ? "R8" : "R2", "hsync", hsync, m_pol[1] ? e_hs : 1 - e_hs);
            chk(tv, "vsync", vsync, m_pol[0] ? e_vs : 1 - e_vs);
            chk(td, "de", de, e_de);
            chk(pending ? "R8" : "R7", "field", field, e_field);
            chk(pending ? "R8" : "R9", "sof", sof, e_sof);

            hs_l = (hsync == m_pol[1]) ? 1 : 0;
            vs_l = (vsync == m_pol[0]) ? 1 : 0;
            // R1: line period between horizontal sync starts
            hs_cnt++;
            if (sof) hs_arm = 0;
            if (hs_l == 1 && hs_prev == 0) begin
                if (hs_arm) chk("R1", "hsync period", hs_cnt, e_htot);
                hs_arm = 1;
                hs_cnt = 0;
            end
            // R6: distance from last visible pixel to vertical sync start
            if (de == 0 && de_prev == 1) de_cnt = 0; else de_cnt++;
            if (vs_l == 1 && vs_prev == 0) begin
                chk(e_shift ? "R6" : "R4", "de fall to vsync",
                    de_cnt, (e_fp + 1) * e_htot - m_ha + (e_shift ? e_mid : 0));
                vs_cnt = 0;
            end else begin
                vs_cnt++;
            end
            if (vs_l == 0 && vs_prev == 1)
                chk(e_shift ? "R6" : "R4", "vsync width", vs_cnt, e_sy * e_htot);
            // R9: distance between start-of-frame strobes
            sof_cnt++;
            if (sof) begin
                if (sof_seen) chk("R9", "frame period", sof_cnt, sof_exp);
                sof_seen = 1;
                sof_cnt = 0;
                sof_exp = e_flen;
            end
            hs_prev = hs_l; vs_prev = vs_l; de_prev = de;
        end
    end

    task automatic wait_frames(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!sof) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        #1;
    endtask

    initial begin
        // progressive set, second-field values deliberately nonzero (R3)
        h_act = 8;  h_fp = 2; h_sw = 3; h_bp = 3;
        v_act = 4;  v_fp = 1; v_sw = 2; v_bp = 1;
        f2_fp = 7;  f2_sw = 7; f2_bp = 7;
        ilace = 0;  halfl = 1; oddf = 1; pol = 2'b01;
        repeat (3) @(negedge clk);
        // R10: reset position and levels
        chk("R10", "h_pos", h_pos, 0);
        chk("R10", "v_pos", v_pos, 0);
        chk("R10", "sof", sof, 1);
        chk("R10", "de", de, 1);
        chk("R10", "field", field, 0);
        chk("R10", "hsync", hsync, 1);
        chk("R10", "vsync", vsync, 0);
        rst_n = 1;
        repeat (150) @(negedge clk);
        #1;
        // R8: mid-frame change to interlaced, odd height, extra line first
        v_act = 5; v_fp = 1; v_sw = 1; v_bp = 2;
        f2_fp = 2; f2_sw = 1; f2_bp = 1;
        ilace = 1; halfl = 0; oddf = 1; pol = 2'b10;
        pending = 1;
        wait_frames(3);
        // R6: half-line shift on
        halfl = 1; pending = 1;
        wait_frames(3);
        // R5: extra line to the second field, both syncs active high
        oddf = 0; pol = 2'b11; pending = 1;
        wait_frames(3);
        // R5 with half line off
        halfl = 0; pending = 1;
        wait_frames(3);
        // new line timing and progressive, both syncs active low
        h_act = 10; h_fp = 1; h_sw = 2; h_bp = 4;
        v_act = 3;  v_fp = 2; v_sw = 1; v_bp = 1;
        f2_fp = 3;  f2_sw = 5; f2_bp = 2;
        ilace = 0;  pol = 2'b00; pending = 1;
        wait_frames(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog: a hung run is a failed check
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule